// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds the per-pin control state for a bank of general-purpose pins and presents it on a simple synchronous register bus. Each pin has seven controls: drive enable (direction), output value, input enable, Schmitt enable, pull enable, pull polarity and a 3-bit function code that picks one of eight alternate functions. The drive enable, output value and function code go straight to the pad ring. The other four controls also drive per-pin outputs toward the pad cells.

Pins are grouped sixteen to a port word. Every control word can be reached at four alias addresses. The base alias writes the whole word. The set alias turns on only the bits written as one, and the clear alias turns off only the bits written as one. On function-code words, a fourth alias performs a masked field update in a single bus write, so software can retarget one pin without a separate read and rewrite. Pin inputs cross into the clock domain through a two-flop synchronizer. They can be read raw, or merged with the output value into a per-pin level view.

Top module: `pinbank_regs`

## Requirements
- R1: After reset every drive enable, output value, input enable, Schmitt enable, pull enable, pull polarity and function code is 0, and every control, level and function word reads back as 0.
- R2: The bus address (default 9 bits) is split as follows. Bits [8:5] hold the word kind: 0 drive enable, 1 output value, 2 input enable, 3 Schmitt enable, 4 pull enable, 5 pull polarity, 6 synchronized input, 7 level view, 8 function codes. Bits [4:2] hold the word index. Bits [1:0] hold the alias: 0 base, 1 set, 2 clear, 3 masked. For kinds 0 to 7, pin p lives in port word p>>4 at bit p&15.
- R3: A base-alias write to a control word replaces its sixteen pin bits. The new value is on the pad outputs in the cycle after the write edge, and the word holds while no write is made.
- R4: A set-alias write sets exactly the bits written as one and leaves the bits written as zero unchanged.
- R5: A clear-alias write clears exactly the bits written as one and leaves the bits written as zero unchanged.
- R6: The following writes change nothing: writes to bits [31:16] of a port word, writes with an index past the last word, writes with alias 3 to kinds 0 to 5, and writes to kinds 6, 7 or 9 to 15. Reserved bits, out-of-range words and kinds 9 to 15 read as 0.
- R7: Function-code word w holds pins 5w to 5w+4. Pin p's 3-bit code sits at bits [3*(p%5)+2 : 3*(p%5)]. Bits [31:15] and the fields of pins past the last pin read as 0. A base write replaces all five fields.
- R8: A masked-alias write to a function-code word updates a code bit only where the matching mask bit in wdata[30:16] is 1, taking the new value from wdata[14:0]. All other fields stay as they were.
- R9: Set and clear aliases on function-code words act bitwise on the 3-bit fields, with the same rules as R4 and R5.
- R10: Kind 6 returns the pin inputs through two flops. A value applied just after a clock edge is returned by a read captured on the third following edge. Reads captured on the first and second edges still return the old value.
- R11: Kind 7 returns, for each pin, the output value when its drive enable is 1 and the synchronized input when it is 0.
- R12: A read strobe on an edge returns the addressed word on rd_data with rd_valid high in the next cycle. rd_valid is low in cycles that follow no strobe.
- R13: The pad outputs pin_oe, pin_out, pin_ie, pin_smt, pin_pull_en and pin_pull_up (1 = pull-up, 0 = pull-down) equal the stored control bits. pin_mux carries pin p's code at bits [3p+2:3p]. Clearing a pull enable removes the bias from that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (9) | Word address: kind, index, alias |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data holds the word for the previous cycle's strobe |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Drive enable per pin |
| pin_ie | output | NUM_PINS | Input enable per pin |
| pin_smt | output | NUM_PINS | Schmitt enable per pin |
| pin_pull_en | output | NUM_PINS | Pull enable per pin |
| pin_pull_up | output | NUM_PINS | Pull polarity per pin |
| pin_mux | output | 3*NUM_PINS | Function code per pin |

## Verification
A write takes effect on the edge that samples it, so the pad outputs are compared at the falling edge that follows that edge. A read captured on an edge is compared one cycle later, at the falling edge where rd_valid is high. The input synchronizer adds two edges. The bench holds pin inputs steady for three cycles before any ordinary read. It also runs one back-to-back read burst that is timed to catch the old value on the first two capture edges and the new value on the third. All stimulus changes on falling edges, so no check races the register updates.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PORT_BITS  = 16;
    localparam int WORD_W     = 32;
    localparam int MUX_W      = 3;
    localparam int MUX_FIELDS = 5;
    localparam int MASK_LSB   = 16;
    localparam int KIND_W     = 4;
    localparam int ALIAS_W    = 2;
    localparam int NUM_CTL    = 6;

    typedef enum logic [ALIAS_W-1:0] {
        AL_BASE = 2'd0,
        AL_SET  = 2'd1,
        AL_CLR  = 2'd2,
        AL_MASK = 2'd3
    } alias_e;

    typedef enum logic [KIND_W-1:0] {
        KD_DIR  = 4'd0,
        KD_DOUT = 4'd1,
        KD_IE   = 4'd2,
        KD_SMT  = 4'd3,
        KD_PEN  = 4'd4,
        KD_PUP  = 4'd5,
        KD_DIN  = 4'd6,
        KD_LVL  = 4'd7,
        KD_MODE = 4'd8
    } kind_e;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // next value of one control bit under a port-word write
    function automatic logic bit_next(logic cur, logic hit, alias_e al, logic b);
        logic n;
        n = cur;
        if (hit) begin
            unique case (al)
                AL_BASE: n = b;
                AL_SET:  n = cur | b;
                AL_CLR:  n = cur & ~b;
                default: n = cur;
            endcase
        end
        return n;
    endfunction

    // next value of one function-code field under a mode-word write
    function automatic logic [MUX_W-1:0] field_next(logic [MUX_W-1:0] cur, logic hit,
                                                    alias_e al, logic [MUX_W-1:0] val,
                                                    logic [MUX_W-1:0] msk);
        logic [MUX_W-1:0] n;
        n = cur;
        if (hit) begin
            unique case (al)
                AL_BASE: n = val;
                AL_SET:  n = cur | val;
                AL_CLR:  n = cur & ~val;
                default: n = (cur & ~msk) | (val & msk);
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/pinbank_bitreg.sv
module pinbank_bitreg
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int IDX_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  alias_e               wr_alias,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [PORT_BITS-1:0] wr_bits,
    output logic [NUM_PINS-1:0]  q
);

    logic [NUM_PINS-1:0] q_nxt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int PORT = i / PORT_BITS;
        localparam int LANE = i % PORT_BITS;
        logic hit;
        assign hit      = wr_en && (wr_idx == IDX_W'(PORT));
        assign q_nxt[i] = bit_next(q[i], hit, wr_alias, wr_bits[LANE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/pinbank_modereg.sv
module pinbank_modereg
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int IDX_W    = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  alias_e                               wr_alias,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic [MASK_LSB+MUX_FIELDS*MUX_W-1:0] wr_data,
    output logic [NUM_PINS-1:0][MUX_W-1:0]       mode
);

    logic [NUM_PINS-1:0][MUX_W-1:0] mode_nxt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int WORD = i / MUX_FIELDS;
        localparam int LSB  = (i % MUX_FIELDS) * MUX_W;
        logic hit;
        assign hit         = wr_en && (wr_idx == IDX_W'(WORD));
        assign mode_nxt[i] = field_next(mode[i], hit, wr_alias,
                                        wr_data[LSB +: MUX_W],
                                        wr_data[MASK_LSB + LSB +: MUX_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else begin
            mode <= mode_nxt;
        end
    end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter  int NUM_PINS   = 32,
    localparam int NUM_PORTS  = (NUM_PINS + PORT_BITS - 1) / PORT_BITS,
    localparam int NUM_MWORDS = (NUM_PINS + MUX_FIELDS - 1) / MUX_FIELDS,
    localparam int IDX_W      = idx_width((NUM_PORTS > NUM_MWORDS) ? NUM_PORTS : NUM_MWORDS),
    localparam int ADDR_W     = KIND_W + IDX_W + ALIAS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  rd_en,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  rd_valid,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_ie,
    output logic [NUM_PINS-1:0]   pin_smt,
    output logic [NUM_PINS-1:0]   pin_pull_en,
    output logic [NUM_PINS-1:0]   pin_pull_up,
    output logic [MUX_W*NUM_PINS-1:0] pin_mux
);

    // address fields
    logic [KIND_W-1:0] bus_kind;
    logic [IDX_W-1:0]  bus_idx;
    alias_e            bus_alias;

    assign bus_kind  = addr[ADDR_W-1 -: KIND_W];
    assign bus_idx   = addr[IDX_W+ALIAS_W-1 : ALIAS_W];
    assign bus_alias = alias_e'(addr[ALIAS_W-1:0]);

    logic unused_bits;
    assign unused_bits = wdata[WORD_W-1];

    // per-pin bit controls: one register per kind 0..NUM_CTL-1
    logic [NUM_PINS-1:0] ctl [NUM_CTL];

    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        logic ctl_we;
        assign ctl_we = wr_en && (bus_kind == KIND_W'(k)) && (bus_alias != AL_MASK);
        pinbank_bitreg #(
            .NUM_PINS (NUM_PINS),
            .IDX_W    (IDX_W)
        ) u_bitreg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ctl_we),
            .wr_alias (bus_alias),
            .wr_idx   (bus_idx),
            .wr_bits  (wdata[PORT_BITS-1:0]),
            .q        (ctl[k])
        );
    end

    // function codes
    logic [NUM_PINS-1:0][MUX_W-1:0] mode;
    logic                           mode_we;

    assign mode_we = wr_en && (bus_kind == KD_MODE);

    pinbank_modereg #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_modereg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_we),
        .wr_alias (bus_alias),
        .wr_idx   (bus_idx),
        .wr_data  (wdata[MASK_LSB+MUX_FIELDS*MUX_W-1:0]),
        .mode     (mode)
    );

    // input synchronizer and level view
    logic [NUM_PINS-1:0] din_s;
    logic [NUM_PINS-1:0] level;

    pinbank_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_s)
    );

    assign level = (ctl[0] & ctl[1]) | (~ctl[0] & din_s);

    // pad outputs
    assign pin_oe      = ctl[0];
    assign pin_out     = ctl[1];
    assign pin_ie      = ctl[2];
    assign pin_smt     = ctl[3];
    assign pin_pull_en = ctl[4];
    assign pin_pull_up = ctl[5];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_mux_out
        assign pin_mux[MUX_W*i +: MUX_W] = mode[i];
    end

    // read path: pick the source vector for port-shaped kinds
    logic [NUM_PINS-1:0] port_src;

    always_comb begin
        port_src = '0;
        for (int k = 0; k < NUM_CTL; k++) begin
            if (bus_kind == KIND_W'(k)) begin
                port_src = ctl[k];
            end
        end
        if (bus_kind == KD_DIN) begin
            port_src = din_s;
        end
        if (bus_kind == KD_LVL) begin
            port_src = level;
        end
    end

    // port words, OR-accumulated by index match
    logic [NUM_PORTS:0][WORD_W-1:0] port_acc;
    assign port_acc[0] = '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pword
        logic [WORD_W-1:0] pw;
        for (genvar b = 0; b < PORT_BITS; b++) begin : g_lane
            localparam int PIN = p * PORT_BITS + b;
            if (PIN < NUM_PINS) begin : g_real
                assign pw[b] = port_src[PIN];
            end else begin : g_pad
                assign pw[b] = 1'b0;
            end
        end
        assign pw[WORD_W-1:PORT_BITS] = '0;
        assign port_acc[p+1] = port_acc[p] | ((bus_idx == IDX_W'(p)) ? pw : '0);
    end

    // function-code words
    logic [NUM_MWORDS:0][WORD_W-1:0] mode_acc;
    assign mode_acc[0] = '0;

    for (genvar w = 0; w < NUM_MWORDS; w++) begin : g_mword
        logic [WORD_W-1:0] mw;
        for (genvar f = 0; f < MUX_FIELDS; f++) begin : g_field
            localparam int PIN = w * MUX_FIELDS + f;
            if (PIN < NUM_PINS) begin : g_real
                assign mw[f*MUX_W +: MUX_W] = mode[PIN];
            end else begin : g_pad
                assign mw[f*MUX_W +: MUX_W] = '0;
            end
        end
        assign mw[WORD_W-1:MUX_FIELDS*MUX_W] = '0;
        assign mode_acc[w+1] = mode_acc[w] | ((bus_idx == IDX_W'(w)) ? mw : '0);
    end

    logic [WORD_W-1:0] rd_word;

    always_comb begin
        if (bus_kind == KD_MODE) begin
            rd_word = mode_acc[NUM_MWORDS];
        end else if (bus_kind <= KD_LVL) begin
            rd_word = port_acc[NUM_PORTS];
        end else begin
            rd_word = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_word;
            end
        end
    end

endmodule

// File: rtl/pinbank_regs_chk.sv
module pinbank_regs_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic                  wr_en,
    input logic [31:0]           wdata,
    input logic                  rd_en,
    input logic [31:0]           rd_data,
    input logic                  rd_valid,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [3*NUM_PINS-1:0] pin_mux
);

    localparam int IDX_W = ADDR_W - 6;

    logic [3:0]       c_kind;
    logic [IDX_W-1:0] c_idx;
    logic [1:0]       c_alias;
    logic             dir_w0;
    logic             unused_chk;

    assign c_kind     = addr[ADDR_W-1 -: 4];
    assign c_idx      = addr[IDX_W+1:2];
    assign c_alias    = addr[1:0];
    assign dir_w0     = wr_en && (c_kind == 4'd0) && (c_idx == '0);
    assign unused_chk = ^{wdata, rd_data[15:0], pin_mux};

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));

    assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w0 && c_alias == 2'd1 && wdata[0]) |=> pin_oe[0]);

    assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w0 && c_alias == 2'd1 && !wdata[0]) |=> $stable(pin_oe[0]));

    assert_clr_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w0 && c_alias == 2'd2 && wdata[0]) |=> !pin_oe[0]);

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && c_kind < 4'd8) |=> (rd_data[31:16] == 16'h0));

    assert_mask_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && c_kind == 4'd8 && c_idx == '0 && c_alias == 2'd3 && wdata[18:16] == 3'b000)
        |=> $stable(pin_mux[2:0]));

    assert_read_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_stray_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind pinbank_regs pinbank_regs_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .pin_oe   (pin_oe),
    .pin_mux  (pin_mux)
);

// File: tb/pinbank_regs_bench.sv
module pinbank_regs_bench;

    localparam int NP    = 32;
    localparam int NPORT = 2;
    localparam int NMW   = 7;
    localparam int AW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_ie, pin_smt, pin_pull_en, pin_pull_up;
    logic [3*NP-1:0] pin_mux;

    pinbank_regs #(.NUM_PINS(NP)) u_pinbank_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .pin_smt(pin_smt),
        .pin_pull_en(pin_pull_en), .pin_pull_up(pin_pull_up), .pin_mux(pin_mux)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NP-1:0] mdl [6];
    logic [2:0]    mmode [NP];
    logic [31:0]   exp_q [$];
    string         req_q [$];

    task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(int kind, int idx, int al);
        return AW'((kind << 5) | (idx << 2) | al);
    endfunction

    function automatic logic [31:0] exp_word(int kind, int idx);
        logic [31:0]   w;
        logic [NP-1:0] src;
        w = '0;
        if (kind <= 7 && idx < NPORT) begin
            if (kind < 6)       src = mdl[kind];
            else if (kind == 6) src = pin_in;
            else                src = (mdl[0] & mdl[1]) | (~mdl[0] & pin_in);
            for (int b = 0; b < 16; b++)
                if (idx * 16 + b < NP) w[b] = src[idx * 16 + b];
        end else if (kind == 8 && idx < NMW) begin
            for (int f = 0; f < 5; f++)
                if (idx * 5 + f < NP) w[3*f +: 3] = mmode[idx * 5 + f];
        end
        return w;
    endfunction

    task automatic wr(int kind, int idx, int al, logic [31:0] d);
        @(negedge clk);
        addr  = mk(kind, idx, al);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (kind < 6 && idx < NPORT && al < 3) begin
            for (int b = 0; b < 16; b++) begin
                if (idx * 16 + b < NP) begin
                    if (al == 0)               mdl[kind][idx*16+b] = d[b];
                    else if (al == 1 && d[b])  mdl[kind][idx*16+b] = 1'b1;
                    else if (al == 2 && d[b])  mdl[kind][idx*16+b] = 1'b0;
                end
            end
        end
        if (kind == 8 && idx < NMW) begin
            for (int f = 0; f < 5; f++) begin
                if (idx * 5 + f < NP) begin
                    logic [2:0] v, m, c;
                    v = d[3*f +: 3];
                    m = d[16 + 3*f +: 3];
                    c = mmode[idx*5+f];
                    case (al)
                        0:       c = v;
                        1:       c = c | v;
                        2:       c = c & ~v;
                        default: c = (c & ~m) | (v & m);
                    endcase
                    mmode[idx*5+f] = c;
                end
            end
        end
    endtask

    task automatic rd(int kind, int idx, string req);
        @(negedge clk);
        addr  = mk(kind, idx, 0);
        rd_en = 1'b1;
        exp_q.push_back(exp_word(kind, idx));
        req_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_pads(string req);
        logic [3*NP-1:0] em;
        for (int i = 0; i < NP; i++) em[3*i +: 3] = mmode[i];
        check(pin_oe === mdl[0],      {req, " pin_oe"},      96'(pin_oe),      96'(mdl[0]));
        check(pin_out === mdl[1],     {req, " pin_out"},     96'(pin_out),     96'(mdl[1]));
        check(pin_ie === mdl[2],      {req, " pin_ie"},      96'(pin_ie),      96'(mdl[2]));
        check(pin_smt === mdl[3],     {req, " pin_smt"},     96'(pin_smt),     96'(mdl[3]));
        check(pin_pull_en === mdl[4], {req, " pin_pull_en"}, 96'(pin_pull_en), 96'(mdl[4]));
        check(pin_pull_up === mdl[5], {req, " pin_pull_up"}, 96'(pin_pull_up), 96'(mdl[5]));
        check(pin_mux === em,         {req, " pin_mux"},     96'(pin_mux),     96'(em));
    endtask

    // monitor: compares each returned word against the queued expectation
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected rd_valid", 96'(rd_data), 96'(0));
            end else begin
                logic [31:0] e;
                string       r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(rd_data === e, r, 96'(rd_data), 96'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_w, new_w;
        for (int k = 0; k < 6; k++) mdl[k] = '0;
        for (int i = 0; i < NP; i++) mmode[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pads("R1");
        rd(0, 0, "R1 dir word");
        rd(8, 0, "R1 mode word");
        rd(1, 1, "R1 dout word");
        rd(7, 1, "R1 level word");

        // R3 base write, upper half ignored (R6)
        wr(0, 0, 0, 32'hFFFF_A5A5);
        check_pads("R3");
        rd(0, 0, "R3 base readback");
        repeat (3) @(negedge clk);
        check_pads("R3 hold");

        // R4 set alias
        wr(0, 0, 1, 32'h0000_000F);
        check_pads("R4");
        rd(0, 0, "R4 set readback");

        // R5 clear alias
        wr(0, 0, 2, 32'h0000_00A0);
        check_pads("R5");
        rd(0, 0, "R5 clear readback");

        // R2 second port mapping
        wr(1, 1, 0, 32'h0000_1234);
        check_pads("R2");
        rd(1, 1, "R2 port1 readback");
        rd(1, 0, "R2 port0 untouched");

        // R6 ignored writes
        wr(0, 0, 3, 32'hFFFF_FFFF);
        check_pads("R6 alias3 on bit kind");
        wr(0, 5, 0, 32'hFFFF_FFFF);
        check_pads("R6 out of range index");
        rd(0, 5, "R6 out of range read");
        wr(9, 0, 0, 32'hFFFF_FFFF);
        check_pads("R6 unused kind write");
        rd(9, 0, "R6 unused kind read");
        rd(15, 1, "R6 unused kind read");
        wr(6, 0, 0, 32'hFFFF_FFFF);
        check_pads("R6 input kind write");

        // R10 and R11 with steady inputs
        pin_in = 32'h3C3C_9669;
        wr(0, 1, 0, 32'h0000_FF00);
        wr(1, 0, 0, 32'h0000_0FF0);
        repeat (3) @(negedge clk);
        rd(6, 0, "R10 din port0");
        rd(6, 1, "R10 din port1");
        rd(7, 0, "R11 level port0");
        rd(7, 1, "R11 level port1");

        // R7 mode base write
        wr(8, 0, 0, 32'hFFFF_58D1);
        check_pads("R7");
        rd(8, 0, "R7 mode word0");
        wr(8, 6, 0, 32'hFFFF_FFFF);
        check_pads("R7 last word");
        rd(8, 6, "R7 partial last word");

        // R8 masked update of one field
        wr(8, 0, 3, 32'h01C0_7FFF);
        check_pads("R8");
        rd(8, 0, "R8 masked readback");
        wr(8, 0, 3, 32'h0000_0000);
        check_pads("R8 empty mask");

        // R9 set and clear on mode words
        wr(8, 1, 1, 32'h0000_4924);
        check_pads("R9 set");
        wr(8, 1, 2, 32'h0000_0C03);
        check_pads("R9 clear");
        rd(8, 1, "R9 readback");

        // R13 pad controls and bias removal
        wr(2, 0, 0, 32'h0000_00FF);
        wr(3, 1, 1, 32'h0000_8001);
        wr(4, 0, 0, 32'h0000_F0F0);
        wr(5, 0, 1, 32'h0000_3000);
        check_pads("R13");
        wr(4, 0, 2, 32'h0000_1000);
        check_pads("R13 bias off");
        rd(4, 0, "R13 pull enable word");
        rd(5, 0, "R13 pull select word");

        // R10 synchronizer latency burst
        @(negedge clk);
        old_w = exp_word(6, 0);
        pin_in = 32'h0000_5AA5;
        new_w = exp_word(6, 0);
        addr  = mk(6, 0, 0);
        rd_en = 1'b1;
        exp_q.push_back(old_w); req_q.push_back("R10 first edge");
        @(negedge clk);
        exp_q.push_back(old_w); req_q.push_back("R10 second edge");
        @(negedge clk);
        exp_q.push_back(new_w); req_q.push_back("R10 third edge");
        @(negedge clk);
        rd_en = 1'b0;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R12 reads outstanding", 96'(exp_q.size()), 96'(0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule